// File: doc/BRIEF.md
# Filtered Timer Input Edge Detector

This block conditions one asynchronous timer input pin and turns a qualified change of its level into a strobe that lasts one clock cycle. A downstream timer takes that strobe either as its count clock or as a capture trigger. The pin first passes through a synchroniser. A sampler then samples it. A level is accepted only when the sampler has seen it on two samples in a row. The accepted level is compared with a stored previous level to find rising edges, falling edges or both.

The sampler runs on every clock cycle in count mode. In capture mode it runs only on cycles where an external prescaler tick is high. An enable input starts and stops detection. The stored level is kept while detection is stopped. If the pin changes during a stop, that change is reported as an edge as soon as detection resumes. The mode and edge-select inputs are changed only while enable is low.

Top module: `tin_edge_detect`

## Requirements
- R1: A synchronous active-low reset clears the synchroniser, the sample history, the stored level and `edgePulse` to 0.
- R2: The pin passes through two synchronising flops. In count mode, when the pin changes just after a clock edge and then stays put, `edgePulse` is high in exactly the 4th cycle after that edge.
- R3: `edgeSel` chooses which accepted changes are reported: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 both.
- R4: A new level is accepted only when two consecutive samples hold the same value. A pulse seen on a single sample produces no report.
- R5: With `captureMode` = 0, a sample is taken on every clock cycle and `sampleTick` has no effect.
- R6: With `captureMode` = 1, a sample is taken only on cycles where `sampleTick` is 1. Without ticks, no level is accepted.
- R7: While `enable` is 0, `edgePulse` stays 0 and both the sample history and the stored level hold their values.
- R8: The stored level starts low. If the pin is high when detection is first enabled, a rising edge is reported at once.
- R9: Two cases are reported as edges right after re-enable. Stopping with the pin high and restarting after it went low reports a falling edge. Stopping with the pin low and restarting after it went high reports a rising edge.
- R10: Each report is a pulse exactly one clock cycle wide.
- R11: The stored level follows every accepted level, whether or not that direction is selected for reporting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | 1 runs detection, 0 holds it |
| captureMode | input | 1 | 0 samples every cycle, 1 samples on `sampleTick` |
| sampleTick | input | 1 | Prescaler sampling tick, used in capture mode |
| edgeSel | input | 2 | Reported edge choice: 00 none, 01 rise, 10 fall, 11 both |
| pinIn | input | 1 | Asynchronous timer input pin |
| edgePulse | output | 1 | One-cycle strobe for a qualified selected edge |

## Verification
The bench targets three latent-edge cases after a reset or a stop. A design that cleared or reloaded the stored level on enable would report nothing in these cases. A design that did not hold state while stopped would report edges during the stop. Glitch tests apply a one-cycle pulse in count mode and a pulse shorter than the tick period in capture mode. A filter that accepted a single sample would emit two pulses in each case. An edge-select test sends rise-fall sequences with only one direction selected. A design that updated the stored level only on reported edges would miss every second edge there. An exact latency probe catches a missing or extra pipeline stage.

// File: rtl/tin_edge_pkg.sv
package tin_edge_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;   // take a sample into the history this cycle
    logic commit;   // allow an agreed level to replace the stored level
  } tin_strobe_t;

endpackage

// File: rtl/tin_edge_ctrl.sv
module tin_edge_ctrl
  import tin_edge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        captureMode,
  input  logic        sampleTick,
  input  edge_sel_e   edgeSel,
  input  logic        rawRise,
  input  logic        rawFall,
  output tin_strobe_t strb,
  output logic        edgePulse
);

  logic sampleGate;
  logic wantRise;
  logic wantFall;
  logic pulseNext;

  // the sampling rate depends on how the edge is used downstream
  always_comb begin
    if (captureMode) sampleGate = sampleTick;
    else             sampleGate = 1'b1;
  end

  always_comb begin
    strb.sample = enable && sampleGate;
    strb.commit = enable && sampleGate;
  end

  assign wantRise  = (edgeSel == SEL_RISE) || (edgeSel == SEL_BOTH);
  assign wantFall  = (edgeSel == SEL_FALL) || (edgeSel == SEL_BOTH);
  assign pulseNext = (rawRise && wantRise) || (rawFall && wantFall);

  always_ff @(posedge clk) begin
    if (!rstN) edgePulse <= 1'b0;
    else       edgePulse <= pulseNext;
  end

endmodule

// File: rtl/tin_edge_dpath.sv
module tin_edge_dpath
  import tin_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  tin_strobe_t strb,
  output logic        rawRise,
  output logic        rawFall,
  output logic        storedLevel
);

  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic [HIST_W-1:0]      histReg;
  logic [HIST_W-1:0]      histNext;
  logic                   agree;
  logic                   accept;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  generate
    if (HIST_W == 1) begin : g_hist_one
      assign histNext = syncOut;
    end else begin : g_hist_many
      assign histNext = {histReg[HIST_W-2:0], syncOut};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)           histReg <= '0;
    else if (strb.sample) histReg <= histNext;
  end

  // current sample agrees with all earlier samples in the window
  assign agree  = (histReg == {HIST_W{syncOut}});
  assign accept = strb.commit && agree;

  assign rawRise = accept && syncOut && !storedLevel;
  assign rawFall = accept && !syncOut && storedLevel;

  always_ff @(posedge clk) begin
    if (!rstN)       storedLevel <= 1'b0;
    else if (accept) storedLevel <= syncOut;
  end

endmodule

// File: rtl/tin_edge_detect.sv
module tin_edge_detect
  import tin_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       captureMode,
  input  logic       sampleTick,
  input  logic [1:0] edgeSel,
  input  logic       pinIn,
  output logic       edgePulse
);

  tin_strobe_t strb;
  logic        rawRise;
  logic        rawFall;
  logic        storedLevel;
  edge_sel_e   selType;

  assign selType = edge_sel_e'(edgeSel);

  tin_edge_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .captureMode (captureMode),
    .sampleTick  (sampleTick),
    .edgeSel     (selType),
    .rawRise     (rawRise),
    .rawFall     (rawFall),
    .strb        (strb),
    .edgePulse   (edgePulse)
  );

  tin_edge_dpath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .strb        (strb),
    .rawRise     (rawRise),
    .rawFall     (rawFall),
    .storedLevel (storedLevel)
  );

endmodule

// File: rtl/tin_edge_checker.sv
module tin_edge_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       captureMode,
  input logic       sampleTick,
  input logic [1:0] edgeSel,
  input logic       edgePulse,
  input logic       storedLevel
);

  p_quiet_stopped_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !edgePulse);

  p_hold_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(storedLevel));

  p_sel_none_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'b00) |=> !edgePulse);

  p_rise_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgePulse && $past(edgeSel) == 2'b01) |-> storedLevel);

  p_fall_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgePulse && $past(edgeSel) == 2'b10) |-> !storedLevel);

  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);

  p_level_moved_r11: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |-> (storedLevel != $past(storedLevel)));

  p_tick_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && captureMode && !sampleTick) |=> !edgePulse);

endmodule

bind tin_edge_detect tin_edge_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .captureMode (captureMode),
  .sampleTick  (sampleTick),
  .edgeSel     (edgeSel),
  .edgePulse   (edgePulse),
  .storedLevel (storedLevel)
);

// File: tb/sim_tin_edge_detect.sv
`timescale 1ns/1ps
module sim_tin_edge_detect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       captureMode = 1'b0;
  logic       sampleTick = 1'b0;
  logic [1:0] edgeSel = 2'b00;
  logic       pinIn = 1'b0;
  logic       edgePulse;

  int vecCnt = 0;
  int errCnt = 0;
  int pulseCnt = 0;
  int widthErr = 0;
  logic prevPulse = 1'b0;
  logic tickOn = 1'b0;
  int tickDiv = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tin_edge_detect u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .captureMode(captureMode),
    .sampleTick(sampleTick), .edgeSel(edgeSel), .pinIn(pinIn),
    .edgePulse(edgePulse)
  );

  // tick generator: one tick every 4 cycles, driven at falling edge
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    sampleTick <= tickOn && (tickDiv == 3);
  end

  // pulse monitor
  always @(negedge clk) begin
    if (edgePulse) pulseCnt++;
    if (edgePulse && prevPulse) widthErr++;
    prevPulse = edgePulse;
  end

  task automatic check(input string req, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic pinLvl);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; pinIn = pinLvl;
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    pulseCnt = 0;
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b1; edgeSel = 2'b11; pinIn = 1'b1;
    cyc(3);
    check("R1 pulse low in reset", int'(edgePulse), 0);
    pinIn = 1'b0;
    cyc(3);
    rstN = 1'b1;
    pulseCnt = 0;
    cyc(10);
    check("R1 no pulse after reset with pin low", pulseCnt, 0);
  endtask

  // R2: exact latency in count mode
  task automatic t_latency();
    do_reset(1'b0);
    captureMode = 1'b0; edgeSel = 2'b11; enable = 1'b1;
    cyc(10);
    pinIn = 1'b1;
    cyc(3);
    check("R2 no pulse before cycle 4", int'(edgePulse), 0);
    cyc(1);
    check("R2 pulse in cycle 4", int'(edgePulse), 1);
    cyc(1);
    check("R10 pulse gone in cycle 5", int'(edgePulse), 0);
  endtask

  // R8: latent rising edge at first enable
  task automatic t_first_enable();
    do_reset(1'b1);
    captureMode = 1'b0; edgeSel = 2'b01;
    cyc(10);
    check("R7 no pulse while disabled", pulseCnt, 0);
    enable = 1'b1;
    cyc(10);
    check("R8 rising at first enable", pulseCnt, 1);
    do_reset(1'b1);
    edgeSel = 2'b10; enable = 1'b1;
    cyc(10);
    check("R8 falling-only sees nothing", pulseCnt, 0);
  endtask

  // R3 and R11: each select over rise, fall, rise, fall
  task automatic t_select(input logic [1:0] sel, input int exp);
    do_reset(1'b0);
    captureMode = 1'b0; edgeSel = sel; enable = 1'b1;
    cyc(5);
    for (int k = 0; k < 4; k++) begin
      pinIn = ~pinIn;
      cyc(10);
    end
    check($sformatf("R3 R11 select %0d pulse count", sel), pulseCnt, exp);
  endtask

  // R4: glitch rejection in count mode
  task automatic t_glitch();
    do_reset(1'b0);
    captureMode = 1'b0; edgeSel = 2'b11; enable = 1'b1;
    cyc(5);
    pinIn = 1'b1; cyc(1); pinIn = 1'b0;
    cyc(10);
    check("R4 one-sample pulse rejected", pulseCnt, 0);
    pinIn = 1'b1; cyc(2); pinIn = 1'b0;
    cyc(10);
    check("R4 two-sample pulse accepted", pulseCnt, 2);
  endtask

  // R5: count mode ignores the tick
  task automatic t_count_no_tick();
    do_reset(1'b0);
    tickOn = 1'b0; captureMode = 1'b0; edgeSel = 2'b01; enable = 1'b1;
    cyc(5);
    pinIn = 1'b1;
    cyc(10);
    check("R5 count mode edge without ticks", pulseCnt, 1);
  endtask

  // R6: capture mode samples only on ticks
  task automatic t_capture();
    do_reset(1'b0);
    tickOn = 1'b1; captureMode = 1'b1; edgeSel = 2'b11; enable = 1'b1;
    cyc(12);
    pinIn = 1'b1; cyc(3); pinIn = 1'b0;
    cyc(20);
    check("R6 pulse shorter than tick period rejected", pulseCnt, 0);
    pinIn = 1'b1; cyc(12); pinIn = 1'b0;
    cyc(20);
    check("R6 long pulse gives rise and fall", pulseCnt, 2);
    tickOn = 1'b0;
    cyc(2);
    pulseCnt = 0;
    pinIn = 1'b1;
    cyc(30);
    check("R6 no acceptance without ticks", pulseCnt, 0);
    tickOn = 1'b1;
    cyc(20);
    check("R6 edge once ticks resume", pulseCnt, 1);
    tickOn = 1'b0;
  endtask

  // R9 and R7: latent edges across a stop
  task automatic t_restart();
    do_reset(1'b0);
    captureMode = 1'b0; edgeSel = 2'b10; enable = 1'b1;
    pinIn = 1'b1;
    cyc(10);
    check("R3 rise not reported with falling select", pulseCnt, 0);
    enable = 1'b0;
    cyc(2);
    pinIn = 1'b0;
    cyc(20);
    check("R7 no pulse during stop", pulseCnt, 0);
    enable = 1'b1;
    cyc(10);
    check("R9 falling reported on restart", pulseCnt, 1);
    enable = 1'b0;
    cyc(2);
    edgeSel = 2'b01;
    pinIn = 1'b1;
    cyc(20);
    check("R7 no pulse during second stop", pulseCnt, 1);
    enable = 1'b1;
    cyc(10);
    check("R9 rising reported on restart", pulseCnt, 2);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_first_enable();
    t_select(2'b00, 0);
    t_select(2'b01, 2);
    t_select(2'b10, 2);
    t_select(2'b11, 4);
    t_glitch();
    t_count_no_tick();
    t_capture();
    t_restart();
    check("R10 every pulse one cycle wide", widthErr, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        vecCnt++;
        errCnt++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule